// File: doc/BRIEF.md
# Programmable Sample-Rate Strobe Generator

This block turns a fixed bus clock into a steady audio sample clock whose rate software chooses from four values. It runs on the bus clock E, which is 1.8432 MHz in the target system. A free-running period counter counts up from zero to a limit that a 2-bit rate code selects. Each time the counter reaches that limit, one sample period ends. For each period the block raises a one-cycle DAC load strobe. It then pulls an active-low FIFO shift-out strobe low, so the byte now at the FIFO head is presented for the next period.

The rate code and a halt bit come from a control register outside the block. A new rate never cuts a period short. The block latches it only at the end of the current period, so software must allow one full period before it relies on the new rate. The shift-out strobe is the OR of a registered pulse and E. It can therefore be low only while E is low, and it stays clear of the rising edge of E, where FIFO status is captured. Setting the halt bit suppresses both strobes, which silences the output. The counter keeps running while halted, so strobes resume on the same period grid.

Top module: `srclk_top`

## Requirements
- R1: While reset is low and after it is released, dac_load is 0 and fifo_so_n is 1. The counter starts cleared, and the active rate code starts at 00 whatever rate_sel holds.
- R2: The rate code maps to a terminal count: 00 gives 0x38, 01 gives 0x72, 10 gives 0xE5 and 11 gives 0xFF. Successive DAC strobes are therefore 57, 115, 230 and 256 E cycles apart.
- R3: The counter counts up from 0 to the terminal count of the active code. It wraps to 0 on the edge where it holds the terminal count, and that edge ends the period.
- R4: A rate code that changes during a period has no effect on that period. It takes effect from the period that follows the next boundary.
- R5: dac_load is high for exactly one E cycle per period. It rises on the rising edge of E that ends the period.
- R6: fifo_so_n is high throughout every high phase of E. It is low during exactly the low phase of the E cycle that follows the DAC strobe cycle.
- R7: If halt is sampled high at a period boundary, that boundary produces neither strobe. The counter keeps counting, so strobes resume on the original period grid once halt is sampled low at a later boundary.
- R8: rate_sel and halt are sampled on the rising edge of E, and the block acts only on the sampled copies.
- R9: The first DAC strobe after reset release comes on the 57th rising edge of E, using code 00. When rate_sel was held at 11 through reset, the second period is 256 cycles long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| e_clk | input | 1 | Bus clock E; all state changes on its rising edge |
| rst_n | input | 1 | Active-low reset |
| rate_sel | input | 2 | Rate code from the control register |
| halt | input | 1 | 1 suppresses strobes from the next boundary on |
| dac_load | output | 1 | One-cycle DAC load strobe, active high |
| fifo_so_n | output | 1 | FIFO shift-out strobe, active low, low only while E is low |

## Verification
The hardest case is the deferred rate change. A new code has to arrive well inside a period, and the bench has to tell apart the period still running at the old length from the first period at the new length. The bench times every change from an observed DAC strobe and then measures two strobe intervals after it. Halt release is handled the same way: the bench lifts halt between grid points computed from the last strobe seen, and checks that the next strobe lands exactly on that grid.

// File: rtl/srclk_pkg.sv
package srclk_pkg;

   // Default width of the period counter.
   localparam int unsigned SRCLK_CNT_W  = 8;
   // Default width of the rate code.
   localparam int unsigned SRCLK_CODE_W = 2;

   // Packed table of terminal counts, code 0 in the lowest byte.
   localparam logic [4*SRCLK_CNT_W-1:0] SRCLK_DEF_COUNTS =
      {8'hFF, 8'hE5, 8'h72, 8'h38};

   // Pick one entry from a packed count table.
   function automatic logic [SRCLK_CNT_W-1:0] srclk_entry(
      input logic [4*SRCLK_CNT_W-1:0] tbl,
      input int unsigned               idx);
      return tbl[idx*SRCLK_CNT_W +: SRCLK_CNT_W];
   endfunction

endpackage

// File: rtl/srclk_rate_map.sv
module srclk_rate_map #(
   parameter int unsigned                       CNT_W  = 8,
   parameter int unsigned                       CODE_W = 2,
   parameter logic [(2**CODE_W)*CNT_W-1:0]      COUNTS = {8'hFF, 8'hE5, 8'h72, 8'h38}
) (
   input  logic [CODE_W-1:0] code,
   output logic [CNT_W-1:0]  limit
);

   localparam int unsigned NCODES = 2**CODE_W;

   logic [CNT_W-1:0] table_q [NCODES];

   // One table entry per code; each must leave at least two counter states.
   for (genvar gi = 0; gi < NCODES; gi++) begin : g_entry
      assign table_q[gi] = COUNTS[gi*CNT_W +: CNT_W];
      if (COUNTS[gi*CNT_W +: CNT_W] == '0) begin : g_bad_zero
         $error("srclk_rate_map: terminal count of code %0d must be nonzero", gi);
      end
   end

   assign limit = table_q[code];

endmodule

// File: rtl/srclk_period_ctr.sv
module srclk_period_ctr #(
   parameter int unsigned                  CNT_W  = 8,
   parameter int unsigned                  CODE_W = 2,
   parameter logic [(2**CODE_W)*CNT_W-1:0] COUNTS = {8'hFF, 8'hE5, 8'h72, 8'h38}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] rate_q,
   input  logic              halt_q,
   output logic              term,
   output logic              fire
);

   logic [CNT_W-1:0]  cnt_q;
   logic [CODE_W-1:0] act_code_q;
   logic [CNT_W-1:0]  limit;

   srclk_rate_map #(
      .CNT_W (CNT_W),
      .CODE_W(CODE_W),
      .COUNTS(COUNTS)
   ) u_map (
      .code (act_code_q),
      .limit(limit)
   );

   assign term = (cnt_q == limit);
   assign fire = term & ~halt_q;

   // The counter wraps at the terminal count. The new code is latched only there.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         act_code_q <= '0;
      end else if (term) begin
         cnt_q      <= '0;
         act_code_q <= rate_q;
      end else begin
         cnt_q      <= cnt_q + 1'b1;
      end
   end

   // R3
   cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= limit)
      else $error("counter beyond terminal count");

   // R4
   code_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !term |=> $stable(act_code_q))
      else $error("active rate changed inside a period");

endmodule

// File: rtl/srclk_strobe_align.sv
module srclk_strobe_align #(
   parameter bit GATE_WITH_CLK = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic dac_load,
   output logic so_n
);

   logic dac_q;
   logic so_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_q <= 1'b0;
         so_q  <= 1'b0;
      end else begin
         dac_q <= fire;
         so_q  <= dac_q;
      end
   end

   assign dac_load = dac_q;

   if (GATE_WITH_CLK) begin : g_gated
      // Low only while the clock is low and the pulse is set.
      assign so_n = ~so_q | clk;
   end else begin : g_full
      assign so_n = ~so_q;
   end

   // R5
   dac_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dac_q |=> !dac_q)
      else $error("DAC strobe longer than one cycle");

endmodule

// File: rtl/srclk_top.sv
module srclk_top #(
   parameter int unsigned                  CNT_W         = srclk_pkg::SRCLK_CNT_W,
   parameter int unsigned                  CODE_W        = srclk_pkg::SRCLK_CODE_W,
   parameter logic [(2**CODE_W)*CNT_W-1:0] COUNTS        = srclk_pkg::SRCLK_DEF_COUNTS,
   parameter bit                           GATE_WITH_CLK = 1'b1
) (
   input  logic              e_clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] rate_sel,
   input  logic              halt,
   output logic              dac_load,
   output logic              fifo_so_n
);

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_w
      $error("srclk_top: CNT_W out of range");
   end
   if (CODE_W < 1 || CODE_W > 4) begin : g_bad_code
      $error("srclk_top: CODE_W out of range");
   end

   logic [CODE_W-1:0] rate_q;
   logic              halt_q;
   logic              term;
   logic              fire;

   // Control inputs are sampled on the rising edge of E.
   always_ff @(posedge e_clk or negedge rst_n) begin
      if (!rst_n) begin
         rate_q <= '0;
         halt_q <= 1'b0;
      end else begin
         rate_q <= rate_sel;
         halt_q <= halt;
      end
   end

   srclk_period_ctr #(
      .CNT_W (CNT_W),
      .CODE_W(CODE_W),
      .COUNTS(COUNTS)
   ) u_ctr (
      .clk   (e_clk),
      .rst_n (rst_n),
      .rate_q(rate_q),
      .halt_q(halt_q),
      .term  (term),
      .fire  (fire)
   );

   srclk_strobe_align #(
      .GATE_WITH_CLK(GATE_WITH_CLK)
   ) u_align (
      .clk     (e_clk),
      .rst_n   (rst_n),
      .fire    (fire),
      .dac_load(dac_load),
      .so_n    (fifo_so_n)
   );

   // R7
   halt_blocks_chk: assert property (@(posedge e_clk) disable iff (!rst_n)
      (term && halt_q) |=> !dac_load)
      else $error("strobe issued while halted");

   // R5
   boundary_strobe_chk: assert property (@(posedge e_clk) disable iff (!rst_n)
      (term && !halt_q) |=> dac_load)
      else $error("boundary without DAC strobe");

endmodule

// File: tb/sim_srclk_top.sv
`timescale 1ns/1ps
module sim_srclk_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] rate_sel = 2'b00;
   logic       halt = 1'b0;
   logic       dac_load;
   logic       fifo_so_n;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int rel = 0;
   int mon_err = 0;
   logic prev_dac = 1'b0;
   bit  done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   srclk_top u0 (
      .e_clk    (clk),
      .rst_n    (rst_n),
      .rate_sel (rate_sel),
      .halt     (halt),
      .dac_load (dac_load),
      .fifo_so_n(fifo_so_n)
   );

   function automatic int exp_len(input logic [1:0] c);
      case (c)
         2'b00:   return 57;
         2'b01:   return 115;
         2'b10:   return 230;
         default: return 256;
      endcase
   endfunction

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // R6 and R5 monitor: high phase, low phase, strobe width
   always @(posedge clk) begin
      #1;
      if (rst_n && fifo_so_n !== 1'b1) mon_err++;
   end
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         if (fifo_so_n !== ~prev_dac) mon_err++;
         if (prev_dac && dac_load) mon_err++;
      end
      prev_dac = dac_load;
   end

   task automatic wait_dac(output int c);
      int n = 0;
      do begin
         @(negedge clk); #1;
         n++;
      end while (!dac_load && n < 2000);
      c = cyc;
   endtask

   task automatic wait_cycles(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); #1;
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      rate_sel = 2'b11;
      halt = 1'b0;
      wait_cycles(5);
      // R1 outputs idle in reset
      check("R1 dac_load in reset", dac_load, 0);
      check("R1 fifo_so_n in reset", fifo_so_n, 1);
      rst_n = 1'b1;
      rel = cyc;
   endtask

   task automatic t_first_period();
      int c1, c2;
      wait_dac(c1);
      // R9 / R1: first period uses code 00
      check("R9 first strobe cycle", c1 - rel, 57);
      wait_dac(c2);
      // R9 / R8: sampled code 11 applies to second period
      check("R9 second period length", c2 - c1, 256);
   endtask

   task automatic t_rate(input logic [1:0] code);
      int s0, s1, s2;
      wait_dac(s0);
      wait_cycles(5);
      rate_sel = code;
      wait_dac(s1);
      wait_dac(s2);
      // R2 / R3 period for each code
      check($sformatf("R2 period code %0d", code), s2 - s1, exp_len(code));
   endtask

   task automatic t_defer();
      int s0, s1, s2;
      rate_sel = 2'b00;
      wait_dac(s0);
      wait_dac(s0);
      wait_cycles(20);
      rate_sel = 2'b10;
      wait_dac(s1);
      // R4 current period keeps old length
      check("R4 old period kept", s1 - s0, 57);
      wait_dac(s2);
      check("R4 new period applied", s2 - s1, 230);
   endtask

   task automatic t_halt();
      int s0, c, seen;
      rate_sel = 2'b00;
      wait_dac(s0);
      wait_dac(s0);
      wait_cycles(10);
      halt = 1'b1;
      seen = 0;
      while (cyc < s0 + 3*57 + 10) begin
         @(negedge clk); #1;
         if (dac_load || !fifo_so_n) seen++;
      end
      // R7 no strobes while halted
      check("R7 strobes during halt", seen, 0);
      halt = 1'b0;
      wait_dac(c);
      // R7 resumed strobe on original grid
      check("R7 resume on grid", c, s0 + 4*57);
   endtask

   initial begin
      t_reset();
      t_first_period();
      t_rate(2'b01);
      t_rate(2'b10);
      t_rate(2'b11);
      t_rate(2'b00);
      t_defer();
      t_halt();
      // R6 / R5 monitor result
      check("R6 shift-out phase monitor", mon_err, 0);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule